// File: doc/BRIEF.md
# Polynomial Self-Test Sequence Checker

This block checks a captured buffer of eight 64-bit words taken from a random number generator that has been put into its deterministic health-check mode. In that mode the generator emits a known sequence produced by a 64-bit Galois shift register. The checker does not know where in that sequence the capture began. It searches for the capture by walking the sequence itself, starting from a fixed seed and advancing one polynomial step per clock cycle.

At every step, the current sequence value is compared in parallel against buffer words 1 to 7. The number of equal words is added to a running total. Word 0 never takes part, because the first captured word is not trusted. The check passes as soon as the total reaches the goal. It fails if the step budget runs out first.

Software or a sequencer loads the buffer through a small indexed write port and then pulses start. When the check ends, done pulses for one cycle together with the verdict, and the verdict stays on pass until the next start. The step counter reports how many polynomial advances were made.

Top module: `seqchk_top`

## Requirements
- R1: After reset, done_o is 0, pass_o is 0 and steps_o is 0.
- R2: The walked sequence starts at seed 0xB8820C7BD387E32C. Each advance shifts the value left by one bit. If bit 63 was set before the shift, the shifted value is then XORed with 0x231DCEE91262B8A3. The value reached after k advances is called seq(k).
- R3: Only buffer words 1 to 7 are compared. Word 0, written with wr_idx_i = 0, never adds to the total.
- R4: At each step, every compared word equal to the current value adds one to the total, so several equal words count together. The total is tested against the goal of 6 before the value advances. On a pass, steps_o equals the number k of advances made before the matching value, and pass_o is 1.
- R5: If 40000 values (seq(0) to seq(39999)) are examined without the total reaching 6, the check ends with pass_o = 0 and steps_o = 40000.
- R6: done_o is high for exactly one cycle, k+1 cycles after the clock edge that samples start_i, where k is the step at which the check ended. pass_o keeps its verdict until the next start.
- R7: A start pulse clears the total, the step counter, done_o and pass_o and reloads the seed, even while a check is running. The check then begins anew.
- R8: A write with wr_en_i stores wr_data_i into word wr_idx_i (0 to 7) when no check is running. Writes made while a check is running are ignored.
- R9: steps_o never exceeds 40000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a check |
| wr_en_i | input | 1 | Buffer word write strobe |
| wr_idx_i | input | 3 | Index of the buffer word to write |
| wr_data_i | input | 64 | Data for the buffer word |
| done_o | output | 1 | One-cycle end-of-check pulse |
| pass_o | output | 1 | Verdict; 1 when the match goal was reached |
| steps_o | output | 16 | Number of polynomial advances made |

## Verification
A wrong sequence value or a miscounted comparison does not stay hidden. It moves the cycle at which done_o pulses and the value on steps_o. The bench therefore checks both the latency and the step count for each buffer pattern, to the exact cycle. A lost or extra accumulation changes the pass step by at least one position, and an ignored or counted word 0 changes it in the dedicated patterns. A buffer corrupted by a write during a run shows up as an earlier pass in the same run. A broken step budget shows up only after the full 40000-cycle walk, as a wrong fail count or a missing done_o.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;
  localparam int          WORD_W     = 64;
  localparam int          NUM_WORDS  = 8;
  localparam int          MATCH_GOAL = 6;
  localparam int          STEP_LIMIT = 40000;
  localparam logic [63:0] SEED       = 64'hB8820C7BD387E32C;
  localparam logic [63:0] POLY       = 64'h231DCEE91262B8A3;

  // One Galois shift step of the health-check sequence.
  function automatic logic [63:0] seq_advance(input logic [63:0] v);
    logic [63:0] sh;
    sh = v << 1;
    return v[63] ? (sh ^ POLY) : sh;
  endfunction
endpackage

// File: rtl/seqchk_wordbuf.sv
module seqchk_wordbuf #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              lock_i,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [WORD_W-1:0]                 wr_data_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic sel;
    assign sel = wr_en_i && !lock_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words_o[g] <= '0;
      else if (sel) words_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/seqchk_matcher.sv
module seqchk_matcher #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  localparam int NUM_CMP  = NUM_WORDS - 1,
  localparam int CNT_W    = $clog2(NUM_CMP + 1)
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  input  logic [WORD_W-1:0]                val_i,
  output logic [NUM_CMP-1:0]               eq_o,
  output logic [CNT_W-1:0]                 hits_o
);
  // word 0 is skipped on purpose
  for (genvar g = 1; g < NUM_WORDS; g++) begin : g_cmp
    assign eq_o[g-1] = (words_i[g] == val_i);
  end

  always_comb begin
    hits_o = '0;
    for (int i = 0; i < NUM_CMP; i++) hits_o = hits_o + CNT_W'(eq_o[i]);
  end
endmodule

// File: rtl/seqchk_ctrl.sv
module seqchk_ctrl
  import seqchk_pkg::*;
#(
  parameter int          GOAL       = 6,
  parameter int          STEP_LIMIT = 40000,
  parameter int          CNT_W      = 3,
  parameter int          TOT_W      = 4,
  parameter int          STEP_W     = 16,
  parameter logic [63:0] SEED_VAL   = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  hits_i,
  output logic [63:0]       cur_val_o,
  output logic [TOT_W-1:0]  total_o,
  output logic              busy_o,
  output logic              goal_hit_o,
  output logic              last_step_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [STEP_W-1:0] steps_o
);
  logic [TOT_W-1:0] sum;

  assign sum         = total_o + TOT_W'(hits_i);
  assign goal_hit_o  = busy_o && (sum >= TOT_W'(GOAL));
  assign last_step_o = busy_o && !goal_hit_o && (steps_o == STEP_W'(STEP_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_val_o <= SEED_VAL;
      total_o   <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      steps_o   <= '0;
    end else if (start_i) begin
      cur_val_o <= SEED_VAL;
      total_o   <= '0;
      busy_o    <= 1'b1;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      steps_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (goal_hit_o) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        pass_o <= 1'b1;
      end else if (busy_o) begin
        cur_val_o <= seq_advance(cur_val_o);
        total_o   <= sum;
        steps_o   <= steps_o + 1'b1;
        if (last_step_o) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seqchk_top.sv
module seqchk_top
  import seqchk_pkg::*;
#(
  parameter int NWORDS = NUM_WORDS,
  parameter int GOAL   = MATCH_GOAL,
  parameter int LIMIT  = STEP_LIMIT,
  localparam int IDX_W  = $clog2(NWORDS),
  localparam int NCMP   = NWORDS - 1,
  localparam int CNT_W  = $clog2(NCMP + 1),
  localparam int TOT_W  = $clog2(GOAL + NCMP + 1),
  localparam int STEP_W = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [63:0]       wr_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [STEP_W-1:0] steps_o
);
  logic [NWORDS-1:0][63:0] words;
  logic [63:0]             cur_val;
  logic [NCMP-1:0]         eq_vec;
  logic [CNT_W-1:0]        hits;
  logic [TOT_W-1:0]        total;
  logic                    busy, goal_hit, last_step;

  seqchk_wordbuf #(.WORD_W(64), .NUM_WORDS(NWORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .lock_i(busy), .wr_en_i(wr_en_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .words_o(words));

  seqchk_matcher #(.WORD_W(64), .NUM_WORDS(NWORDS)) u_match (
    .words_i(words), .val_i(cur_val), .eq_o(eq_vec), .hits_o(hits));

  seqchk_ctrl #(.GOAL(GOAL), .STEP_LIMIT(LIMIT), .CNT_W(CNT_W), .TOT_W(TOT_W),
                .STEP_W(STEP_W), .SEED_VAL(SEED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hits_i(hits),
    .cur_val_o(cur_val), .total_o(total), .busy_o(busy),
    .goal_hit_o(goal_hit), .last_step_o(last_step),
    .done_o(done_o), .pass_o(pass_o), .steps_o(steps_o));
endmodule

// File: rtl/seqchk_sva.sv
module seqchk_sva
  import seqchk_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int LIMIT  = 40000,
  parameter int TOT_W  = 4,
  parameter int STEP_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    done_o,
  input logic                    pass_o,
  input logic [STEP_W-1:0]       steps_o,
  input logic                    busy,
  input logic                    goal_hit,
  input logic [63:0]             cur_val,
  input logic [TOT_W-1:0]        total,
  input logic [NWORDS-1:0][63:0] words
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done_o && !pass_o && $past(!rst_n)) |-> (steps_o == '0));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !goal_hit && !start_i) |=> (cur_val == seq_advance($past(cur_val))));

  assert_pass_in_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pass_o) |-> (steps_o < STEP_W'(LIMIT)));

  assert_fail_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !pass_o) |-> (steps_o == STEP_W'(LIMIT)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_pass_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> done_o);

  assert_pass_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o && !start_i) |=> pass_o);

  assert_start_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy && cur_val == SEED && total == '0 && steps_o == '0 && !done_o && !pass_o));

  assert_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(words));

  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    steps_o <= STEP_W'(LIMIT));
endmodule

bind seqchk_top seqchk_sva #(.NWORDS(NWORDS), .LIMIT(LIMIT), .TOT_W(TOT_W), .STEP_W(STEP_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .pass_o(pass_o),
  .steps_o(steps_o), .busy(busy), .goal_hit(goal_hit), .cur_val(cur_val),
  .total(total), .words(words));

// File: tb/seqchk_top_tb.sv
module seqchk_top_tb;
  localparam logic [63:0] TB_SEED = 64'hB8820C7BD387E32C;
  localparam logic [63:0] TB_POLY = 64'h231DCEE91262B8A3;
  localparam int          TB_LIMIT = 40000;
  localparam int          NV = 6;
  // buffer contents as sequence indices (-1 = zero word), word 0 first
  localparam int VIDX [NV][8] = '{
    '{-1,  0,  1,  2,  3,  4,  5, -1},
    '{-1, 10, 10, 10, 10, 10, 10, -1},
    '{ 0,  0,  0,  0,  0,  0,  3, -1},
    '{-1,  0,  0,  0,  0,  0,  0,  0},
    '{-1, 20, 21, 22, 23, 24, 25, 26},
    '{ 5,  7,  7,  7,  2,  2,  2, -1}};
  localparam int VEXP [NV] = '{5, 10, 3, 0, 25, 7};

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic done_o, pass_o;
  logic [15:0] steps_o;
  int n_tests = 0, n_fail = 0;
  int lat;

  always #10 clk = ~clk;

  seqchk_top u_dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_en_i(wr_en_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .done_o(done_o), .pass_o(pass_o),
    .steps_o(steps_o));

  function automatic logic [63:0] seq_at(input int k);
    logic [63:0] v = TB_SEED;
    for (int i = 0; i < k; i++)
      v = {v[62:0], 1'b0} ^ ({64{v[63]}} & TB_POLY);
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic load(input int idx [8]);
    for (int w = 0; w < 8; w++) wr(w, idx[w] < 0 ? 64'h0 : seq_at(idx[w]));
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // counts negedges after the start pulse until done is seen
  task automatic wait_done();
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done_o && lat < TB_LIMIT + 10);
  endtask

  task automatic check_end(input string req, input logic exp_pass, input int exp_steps);
    chk({req, " done"}, done_o, 1'b1);
    chk({req, " pass"}, pass_o, exp_pass);
    chk({req, " steps"}, steps_o, 64'(exp_steps));
    chk({"R6 latency ", req}, lat, 64'(exp_steps + (exp_pass ? 1 : 0)));
    @(negedge clk);
    chk("R6 done one cycle", done_o, 1'b0);
    chk("R6 pass held", pass_o, exp_pass);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done_o, 1'b0);
    chk("R1 pass", pass_o, 1'b0);
    chk("R1 steps", steps_o, 64'd0);
    rst_n = 1'b1;

    // vector table: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      load(VIDX[v]);
      pulse_start();
      wait_done();
      check_end($sformatf("R4 vec%0d", v), 1'b1, VEXP[v]);
    end

    // R7: start clears a held pass
    pulse_start();
    chk("R7 pass cleared", pass_o, 1'b0);
    chk("R7 steps cleared", steps_o, 64'd0);
    wait_done();

    // R8: write during run ignored (would pass at step 4 if taken)
    load(VIDX[0]);
    pulse_start();
    wr_en_i = 1'b1; wr_idx_i = 3'd7; wr_data_i = seq_at(3);
    @(negedge clk); wr_en_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin @(negedge clk); lat++; end
    check_end("R8 locked write", 1'b1, 5);

    // R7: restart in the middle of a run
    load(VIDX[1]);
    pulse_start();
    repeat (4) @(negedge clk);
    chk("R7 still running", done_o, 1'b0);
    pulse_start();
    wait_done();
    check_end("R7 restart", 1'b1, 10);

    // R5 R9: no matches, budget runs out
    for (int w = 0; w < 8; w++) wr(w, 64'h0);
    pulse_start();
    wait_done();
    check_end("R5 fail", 1'b0, TB_LIMIT);

    // R4 boundary: goal met on the last allowed value
    for (int w = 1; w < 7; w++) wr(w, seq_at(TB_LIMIT - 1));
    pulse_start();
    wait_done();
    check_end("R4 last step", 1'b1, TB_LIMIT - 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule